// File: doc/BRIEF.md
# Asynchronous Serial Port with Queued Data and Hardware Handshake

This block is a full-duplex asynchronous serial port. The host writes bytes into a 64-entry transmit queue and reads bytes out of a 64-entry receive queue. Both queues report how many bytes they hold. The transmitter sends each queued byte as one 11-bit frame. The receiver oversamples the incoming line, rebuilds each byte and queues it. An external single-cycle enable sets the bit timing: it pulses sixteen times per bit period. Dividing the system clock down to that rate is left to the surrounding logic.

Two handshake lines let two ports pace each other. The ready-to-send output reports that the local receive queue has filled up to a threshold that software sets. The clear-to-send input is sampled only between frames. When it is high, no new frame starts, but a frame already on the line always completes. A single enable bit turns the handshake on. With it off, the ready-to-send output stays low and the clear-to-send input is ignored.

Top module: `uart_flowctl`

## Requirements
- R1: Each frame on `txd` is 11 bits: a start bit of 0, data bits D0 to D7 least significant first, a parity bit, then a stop bit of 1. Each bit lasts 16 `baudTick` pulses. `txd` is 1 whenever no frame is being sent.
- R2: The parity bit is the XOR of the eight data bits when `cfgOddParity` is 0, and the inverse of that XOR when it is 1.
- R3: The transmit queue holds up to 64 bytes and `txCount` gives its occupancy. `txFull` is 1 at 64 bytes. A push while full is dropped, leaves `txCount` at 64 and sets the sticky flag `txOverflow`.
- R4: The receiver reacts to a falling edge on `rxd` and checks the start bit again 8 ticks later. A low pulse that has ended by then starts no frame. Received bytes enter the receive queue in arrival order. `rxData` shows the oldest byte, a one-cycle `rxPop` removes it, and `rxCount` and `rxEmpty` report occupancy.
- R5: If the stop bit is sampled as 0, the byte is discarded and the sticky flag `rxFrameErr` is set.
- R6: A valid frame that completes while the receive queue holds 64 bytes is dropped. It sets the sticky flag `rxOverrun`, and `rxCount` stays at 64.
- R7: With `cfgFlowEn` set, `rts` is 1 exactly when `rxCount` is greater than or equal to `cfgRtsLevel`, following changes of either in the same cycle.
- R8: With `cfgFlowEn` set, `cts` is synchronized over two clock stages. While the synchronized value is 1, no new frame starts. A frame already started finishes through its stop bit. When `cts` returns to 0, the next queued byte is sent.
- R9: With `cfgFlowEn` clear, `rts` is 0 and `cts` has no effect on transmission.
- R10: After reset, `txd` is 1, `rts` is 0, both counts are 0, `rxEmpty` is 1 and all sticky flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | Single-cycle enable, 16 pulses per bit |
| cfgFlowEn | input | 1 | Enables the rts/cts handshake |
| cfgOddParity | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfgRtsLevel | input | 7 | Receive occupancy at which rts rises |
| txData | input | 8 | Byte to queue for sending |
| txPush | input | 1 | Writes txData into the transmit queue |
| txFull | output | 1 | Transmit queue holds 64 bytes |
| txCount | output | 7 | Transmit queue occupancy |
| txOverflow | output | 1 | Sticky: a push was dropped |
| rxData | output | 8 | Oldest received byte |
| rxPop | input | 1 | Removes the oldest received byte |
| rxEmpty | output | 1 | Receive queue is empty |
| rxCount | output | 7 | Receive queue occupancy |
| rxOverrun | output | 1 | Sticky: a received byte found the queue full |
| rxFrameErr | output | 1 | Sticky: a stop bit was sampled as 0 |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| rts | output | 1 | Ready-to-send handshake output |
| cts | input | 1 | Clear-to-send handshake input |

## Verification
The bench loops the serial output back to the input. It decodes every frame bit by bit for several data values under both parity settings, so a swapped bit order, an inverted parity rule or a short stop bit shows up directly. It raises `cts` part way through a frame and expects that frame to finish intact and the next one to wait. A design that cut the frame short, or that ignored the pause, would show a broken frame or early activity on `txd`. It fills both queues to 64, so an off-by-one full test would accept the extra byte or lose one of the 64. It sweeps the `rts` threshold across every level at every occupancy from 64 down to 0, which exposes a strict-versus-inclusive comparison. It also drives a too-short start pulse and a frame with a zero stop bit, which a receiver without mid-bit validation or stop checking would accept as data.

// File: rtl/uart_flowctl_pkg.sv
package uart_flowctl_pkg;

  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 3;   // start, data, parity, stop
  localparam int unsigned BIT_CNT_W  = $clog2(FRAME_BITS + 1);

  // Strobes issued by the control unit to the datapath, one cycle each.
  typedef struct packed {
    logic txLoad;    // pop the transmit queue head into the shifter
    logic txShift;   // advance the transmit shifter by one bit
    logic rxShift;   // capture the current line sample as a data bit
    logic rxCommit;  // stop bit sampled: queue the byte or flag an error
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

endpackage

// File: rtl/uart_flowctl_fifo.sv
module uart_flowctl_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             doWrite;
  logic             doRead;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign doWrite = wrEn && !full;
  assign doRead  = rdEn && !empty;
  assign rdData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doRead)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doWrite, doRead})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_flowctl_ctrl.sv
module uart_flowctl_ctrl
  import uart_flowctl_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             cfgFlowEn,
  input  logic [CNT_W-1:0] cfgRtsLevel,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txEmpty,
  input  logic             ctsSync,
  input  logic             rxBit,
  output ctrlStrobes_t     strobes,
  output logic             rts
);

  localparam int unsigned TICK_W = $clog2(OVERSAMPLE);
  localparam logic [TICK_W-1:0]    LAST_TICK = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0]    MID_TICK  = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [BIT_CNT_W-1:0] TX_LAST   = BIT_CNT_W'(FRAME_BITS - 1);
  localparam logic [BIT_CNT_W-1:0] RX_LAST   = BIT_CNT_W'(DATA_BITS);     // parity slot
  localparam logic [BIT_CNT_W-1:0] RX_DATA_N = BIT_CNT_W'(DATA_BITS);

  // ---------------- transmit sequencing ----------------
  logic                 txBusy;
  logic [TICK_W-1:0]    txTick;
  logic [BIT_CNT_W-1:0] txBitIdx;
  logic                 txGo;
  logic                 txBitEnd;

  // R8/R9: handshake only gates the start of a new frame
  assign txGo     = !txBusy && !txEmpty && !(cfgFlowEn && ctsSync);
  assign txBitEnd = txBusy && baudTick && (txTick == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      txTick   <= '0;
      txBitIdx <= '0;
    end else if (txGo) begin
      txBusy   <= 1'b1;
      txTick   <= '0;
      txBitIdx <= '0;
    end else if (txBusy && baudTick) begin
      if (txTick == LAST_TICK) begin
        txTick <= '0;
        if (txBitIdx == TX_LAST) txBusy <= 1'b0;
        else                     txBitIdx <= txBitIdx + 1'b1;
      end else begin
        txTick <= txTick + 1'b1;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  rxState_t             rxState;
  logic [TICK_W-1:0]    rxTick;
  logic [BIT_CNT_W-1:0] rxBitIdx;
  logic                 rxPrev;
  logic                 rxBitEnd;

  assign rxBitEnd = baudTick && (rxTick == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxTick   <= '0;
      rxBitIdx <= '0;
      rxPrev   <= 1'b1;
    end else begin
      rxPrev <= rxBit;
      case (rxState)
        RX_IDLE: begin
          // R4: only a falling edge may begin a frame
          if (rxPrev && !rxBit) begin
            rxState <= RX_START;
            rxTick  <= '0;
          end
        end
        RX_START: begin
          if (baudTick) begin
            if (rxTick == MID_TICK) begin
              rxTick   <= '0;
              rxBitIdx <= '0;
              rxState  <= rxBit ? RX_IDLE : RX_BITS;   // R4 mid-bit validation
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (baudTick) begin
            if (rxTick == LAST_TICK) begin
              rxTick <= '0;
              if (rxBitIdx == RX_LAST) rxState  <= RX_STOP;
              else                     rxBitIdx <= rxBitIdx + 1'b1;
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
        default: begin  // RX_STOP
          if (baudTick) begin
            if (rxTick == LAST_TICK) begin
              rxTick  <= '0;
              rxState <= RX_IDLE;
            end else begin
              rxTick <= rxTick + 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.txLoad   = txGo;
    strobes.txShift  = txBitEnd;
    strobes.rxShift  = (rxState == RX_BITS) && rxBitEnd && (rxBitIdx < RX_DATA_N);
    strobes.rxCommit = (rxState == RX_STOP) && rxBitEnd;
  end

  // R7/R9: ready-to-send follows receive occupancy against the threshold
  assign rts = cfgFlowEn && (rxCount >= cfgRtsLevel);

endmodule

// File: rtl/uart_flowctl_dpath.sv
module uart_flowctl_dpath
  import uart_flowctl_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 cfgOddParity,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 txPush,
  input  logic                 rxPop,
  input  logic                 rxdPin,
  input  logic                 ctsPin,
  output logic                 txd,
  output logic                 rxBit,
  output logic                 ctsSync,
  output logic                 txEmpty,
  output logic                 txFull,
  output logic [CNT_W-1:0]     txCount,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxEmpty,
  output logic [CNT_W-1:0]     rxCount,
  output logic                 txOverflow,
  output logic                 rxOverrun,
  output logic                 rxFrameErr
);

  logic [DATA_BITS-1:0]  txHead;
  logic                  txParity;
  logic [FRAME_BITS-1:0] txShreg;
  logic [DATA_BITS-1:0]  rxShreg;
  logic                  rxFull;
  logic                  rxQueueWr;
  logic [1:0]            rxPipe;
  logic [1:0]            ctsPipe;

  // R3: transmit queue
  uart_flowctl_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_BITS)) uTxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (txPush),
    .wrData (txData),
    .rdEn   (strobes.txLoad),
    .rdData (txHead),
    .count  (txCount),
    .full   (txFull),
    .empty  (txEmpty)
  );

  // R4/R6: receive queue, written only for frames with a good stop bit
  assign rxQueueWr = strobes.rxCommit && rxBit;

  uart_flowctl_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_BITS)) uRxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (rxQueueWr),
    .wrData (rxShreg),
    .rdEn   (rxPop),
    .rdData (rxData),
    .count  (rxCount),
    .full   (rxFull),
    .empty  (rxEmpty)
  );

  // R2: parity over the byte about to be framed
  assign txParity = (^txHead) ^ cfgOddParity;

  // R1: frame shifter, LSB on the line, refills with idle ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txShreg <= '1;
    else if (strobes.txLoad)  txShreg <= {1'b1, txParity, txHead, 1'b0};
    else if (strobes.txShift) txShreg <= {1'b1, txShreg[FRAME_BITS-1:1]};
  end
  assign txd = txShreg[0];

  // Line synchronizers (R4, R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPipe  <= 2'b11;
      ctsPipe <= 2'b00;
    end else begin
      rxPipe  <= {rxPipe[0], rxdPin};
      ctsPipe <= {ctsPipe[0], ctsPin};
    end
  end
  assign rxBit   = rxPipe[1];
  assign ctsSync = ctsPipe[1];

  // Receive deserializer: first bit ends up in bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxShreg <= '0;
    else if (strobes.rxShift) rxShreg <= {rxBit, rxShreg[DATA_BITS-1:1]};
  end

  // R3/R5/R6: sticky error flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverflow <= 1'b0;
      rxOverrun  <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      if (txPush && txFull)                     txOverflow <= 1'b1;
      if (strobes.rxCommit && rxBit && rxFull)  rxOverrun  <= 1'b1;
      if (strobes.rxCommit && !rxBit)           rxFrameErr <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
  import uart_flowctl_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned OVERSAMPLE = 16,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 cfgFlowEn,
  input  logic                 cfgOddParity,
  input  logic [CNT_W-1:0]     cfgRtsLevel,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 txPush,
  output logic                 txFull,
  output logic [CNT_W-1:0]     txCount,
  output logic                 txOverflow,
  output logic [DATA_BITS-1:0] rxData,
  input  logic                 rxPop,
  output logic                 rxEmpty,
  output logic [CNT_W-1:0]     rxCount,
  output logic                 rxOverrun,
  output logic                 rxFrameErr,
  output logic                 txd,
  input  logic                 rxd,
  output logic                 rts,
  input  logic                 cts
);

  ctrlStrobes_t strobes;
  logic         txEmpty;
  logic         rxBit;
  logic         ctsSync;

  uart_flowctl_ctrl #(.OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .cfgFlowEn   (cfgFlowEn),
    .cfgRtsLevel (cfgRtsLevel),
    .rxCount     (rxCount),
    .txEmpty     (txEmpty),
    .ctsSync     (ctsSync),
    .rxBit       (rxBit),
    .strobes     (strobes),
    .rts         (rts)
  );

  uart_flowctl_dpath #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cfgOddParity (cfgOddParity),
    .txData       (txData),
    .txPush       (txPush),
    .rxPop        (rxPop),
    .rxdPin       (rxd),
    .ctsPin       (cts),
    .txd          (txd),
    .rxBit        (rxBit),
    .ctsSync      (ctsSync),
    .txEmpty      (txEmpty),
    .txFull       (txFull),
    .txCount      (txCount),
    .rxData       (rxData),
    .rxEmpty      (rxEmpty),
    .rxCount      (rxCount),
    .txOverflow   (txOverflow),
    .rxOverrun    (rxOverrun),
    .rxFrameErr   (rxFrameErr)
  );

endmodule

// File: rtl/uart_flowctl_chk.sv
module uart_flowctl_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgFlowEn,
  input logic [CNT_W-1:0] cfgRtsLevel,
  input logic             txPush,
  input logic             txFull,
  input logic [CNT_W-1:0] txCount,
  input logic             txOverflow,
  input logic [CNT_W-1:0] rxCount,
  input logic             rxOverrun,
  input logic             rxFrameErr,
  input logic             rts
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  assert_rts_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgFlowEn |-> !rts);

  assert_rts_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    rts |-> (cfgFlowEn && rxCount >= cfgRtsLevel));

  assert_rts_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFlowEn && !rts) |-> (rxCount < cfgRtsLevel));

  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull) |=> txOverflow);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |=> txOverflow);

  assert_full_no_grow_R3: assert property (@(posedge clk) disable iff (!rstN)
    txFull |=> (txCount <= $past(txCount)));

  assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= MAX_CNT);

  assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= MAX_CNT);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |=> rxOverrun);

  assert_frame_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |=> rxFrameErr);

endmodule

bind uart_flowctl uart_flowctl_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgFlowEn   (cfgFlowEn),
  .cfgRtsLevel (cfgRtsLevel),
  .txPush      (txPush),
  .txFull      (txFull),
  .txCount     (txCount),
  .txOverflow  (txOverflow),
  .rxCount     (rxCount),
  .rxOverrun   (rxOverrun),
  .rxFrameErr  (rxFrameErr),
  .rts         (rts)
);

// File: tb/tb_uart_flowctl.sv
module tb_uart_flowctl;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OVS        = 16;
  localparam int BIT_CYC    = TICK_DIV * OVS;
  localparam int DEPTH      = 64;
  localparam int CNT_W      = 7;
  localparam int WATCHDOG   = 190000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             baudTick = 1'b0;
  logic             cfgFlowEn = 1'b0;
  logic             cfgOddParity = 1'b0;
  logic [CNT_W-1:0] cfgRtsLevel = 7'd8;
  logic [7:0]       txData = '0;
  logic             txPush = 1'b0;
  logic             txFull;
  logic [CNT_W-1:0] txCount;
  logic             txOverflow;
  logic [7:0]       rxData;
  logic             rxPop = 1'b0;
  logic             rxEmpty;
  logic [CNT_W-1:0] rxCount;
  logic             rxOverrun;
  logic             rxFrameErr;
  logic             txd;
  logic             rts;
  logic             cts = 1'b0;
  logic             loopEn = 1'b1;
  logic             benchRxd = 1'b1;
  logic             rxdLine;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  assign rxdLine = loopEn ? txd : benchRxd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flowctl #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(OVS)) dut (
    .clk (clk), .rstN (rstN), .baudTick (baudTick),
    .cfgFlowEn (cfgFlowEn), .cfgOddParity (cfgOddParity), .cfgRtsLevel (cfgRtsLevel),
    .txData (txData), .txPush (txPush), .txFull (txFull), .txCount (txCount),
    .txOverflow (txOverflow), .rxData (rxData), .rxPop (rxPop), .rxEmpty (rxEmpty),
    .rxCount (rxCount), .rxOverrun (rxOverrun), .rxFrameErr (rxFrameErr),
    .txd (txd), .rxd (rxdLine), .rts (rts), .cts (cts)
  );

  // 16x tick: one pulse every TICK_DIV cycles
  initial begin
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % TICK_DIV;
      baudTick = (phase == 0);
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
    end
  end

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    txData = b;
    txPush = 1'b1;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popByte(output logic [7:0] b);
    @(negedge clk);
    b = rxData;
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  // Decode one frame from txd, sampling each bit near its middle
  task automatic decodeTx(output logic [7:0] d, output logic p, output logic st, output logic sp);
    int w;
    w = 0;
    @(negedge clk);
    while (txd !== 1'b0 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    repeat (BIT_CYC/2) @(negedge clk);
    st = txd;
    for (int k = 0; k < 8; k++) begin
      repeat (BIT_CYC) @(negedge clk);
      d[k] = txd;
    end
    repeat (BIT_CYC) @(negedge clk);
    p = txd;
    repeat (BIT_CYC) @(negedge clk);
    sp = txd;
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic p, input logic sp);
    logic [10:0] bits;
    bits = {sp, p, b, 1'b0};
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      benchRxd = bits[k];
      repeat (BIT_CYC-1) @(negedge clk);
    end
    @(negedge clk);
    benchRxd = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  function automatic logic [7:0] seqVal(input int i);
    return 8'((i * 3 + 1) & 8'hFF);
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] got;
    logic p, st, sp;
    logic [7:0] pat [6];
    int bad;
    int expCnt;

    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5;
    pat[3] = 8'h3C; pat[4] = 8'h01; pat[5] = 8'h80;

    // ---------- R10: reset state ----------
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R10", "txd idle", txd, 1);
    chkEq("R10", "rts", rts, 0);
    chkEq("R10", "txCount", txCount, 0);
    chkEq("R10", "rxCount", rxCount, 0);
    chkEq("R10", "rxEmpty", rxEmpty, 1);
    chkEq("R10", "flags", {txOverflow, rxOverrun, rxFrameErr}, 0);

    // ---------- R1, R2, R4, R9: loopback with handshake off, cts high ----------
    cfgFlowEn = 1'b0;
    cts = 1'b1;
    loopEn = 1'b1;
    for (int k = 0; k < 12; k++) begin
      cfgOddParity = k[0];
      pushByte(pat[k % 6]);
      decodeTx(d, p, st, sp);
      chkEq("R1", "start bit", st, 0);
      chkEq("R1", "data bits LSB first", d, pat[k % 6]);
      chkEq("R2", "parity bit", p, (^pat[k % 6]) ^ k[0]);
      chkEq("R1", "stop bit", sp, 1);
      repeat (BIT_CYC) @(negedge clk);
      chkEq("R1", "txd idle between frames", txd, 1);
    end
    chkEq("R4", "rxCount after 12 frames", rxCount, 12);
    chkEq("R9", "rts low with handshake off", rts, 0);
    for (int k = 0; k < 12; k++) begin
      popByte(got);
      chkEq("R4", "received order", got, pat[k % 6]);
    end
    chkEq("R4", "rxEmpty after draining", rxEmpty, 1);

    // ---------- R4: short low pulse is not a start bit ----------
    loopEn = 1'b0;
    @(negedge clk);
    benchRxd = 1'b0;
    repeat (BIT_CYC/4) @(negedge clk);
    benchRxd = 1'b1;
    repeat (4 * BIT_CYC) @(negedge clk);
    chkEq("R4", "false start rejected", rxCount, 0);
    sendFrame(8'h5A, ^8'h5A, 1'b1);
    chkEq("R4", "valid bench frame queued", rxCount, 1);
    popByte(got);
    chkEq("R4", "bench frame data", got, 8'h5A);

    // ---------- R5: zero stop bit ----------
    sendFrame(8'h77, ^8'h77, 1'b0);
    repeat (BIT_CYC) @(negedge clk);
    chkEq("R5", "frame error flag", rxFrameErr, 1);
    chkEq("R5", "bad frame discarded", rxCount, 0);
    sendFrame(8'hC3, ^8'hC3, 1'b1);
    chkEq("R5", "reception after error", rxCount, 1);
    popByte(got);
    chkEq("R5", "byte after error", got, 8'hC3);
    chkEq("R5", "frame error sticky", rxFrameErr, 1);

    // ---------- R3, R8: blocked transmitter, fill queue ----------
    loopEn = 1'b1;
    cfgOddParity = 1'b0;
    cfgFlowEn = 1'b1;
    cts = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) pushByte(seqVal(i));
    chkEq("R3", "txCount at full", txCount, DEPTH);
    chkEq("R3", "txFull", txFull, 1);
    chkEq("R3", "no overflow yet", txOverflow, 0);
    bad = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chkEq("R8", "cts high holds line idle (non-idle cycles)", bad, 0);
    pushByte(8'hEE);
    chkEq("R3", "overflow flag", txOverflow, 1);
    chkEq("R3", "txCount unchanged by dropped push", txCount, DEPTH);

    // ---------- R8: pause raised mid-frame ----------
    cts = 1'b0;
    fork
      decodeTx(d, p, st, sp);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (100) @(negedge clk);
        cts = 1'b1;
      end
    join
    chkEq("R8", "frame in flight completes: data", d, seqVal(0));
    chkEq("R8", "frame in flight completes: stop", sp, 1);
    bad = 0;
    for (int c = 0; c < 3 * 11 * BIT_CYC; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chkEq("R8", "no new frame while paused (non-idle cycles)", bad, 0);
    chkEq("R8", "queue holds remaining bytes", txCount, DEPTH - 1);
    chkEq("R8", "one byte delivered", rxCount, 1);

    cts = 1'b0;
    begin
      int w;
      w = 0;
      while (rxCount != 7'(DEPTH) && w < 60000) begin
        @(negedge clk);
        w++;
      end
    end
    chkEq("R8", "transmission resumed, receive queue full", rxCount, DEPTH);
    chkEq("R3", "transmit queue drained", txCount, 0);

    // ---------- R6: overrun ----------
    pushByte(8'hEE);
    decodeTx(d, p, st, sp);
    repeat (BIT_CYC) @(negedge clk);
    chkEq("R6", "overrun flag", rxOverrun, 1);
    chkEq("R6", "rxCount stays at depth", rxCount, DEPTH);

    // ---------- R9: rts forced low with handshake off at full queue ----------
    cfgFlowEn = 1'b0;
    cfgRtsLevel = 7'd0;
    #1;
    chkEq("R9", "rts with handshake off", rts, 0);
    cfgFlowEn = 1'b1;

    // ---------- R7: threshold sweep at every occupancy; R4 order ----------
    expCnt = DEPTH;
    for (int step = 0; step <= DEPTH; step++) begin
      chkEq("R7", "rxCount tracking", rxCount, expCnt);
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
        @(negedge clk);
        cfgRtsLevel = 7'(lvl);
        #1;
        chkEq("R7", $sformatf("rts count %0d level %0d", expCnt, lvl), rts, (expCnt >= lvl) ? 1 : 0);
      end
      if (expCnt > 0) begin
        popByte(got);
        chkEq("R4", "queue order after pause and overrun", got, seqVal(DEPTH - expCnt));
        expCnt--;
      end
    end
    chkEq("R4", "rxEmpty at end", rxEmpty, 1);

    done = 1'b1;
    summary();
  end

endmodule